// File: doc/BRIEF.md
# Destination Address Perfect-Match Filter

This block keeps a small table of station addresses, programmed by register writes, and checks the destination address of every received Ethernet frame against each valid entry. The receive side delivers one byte per accepted cycle together with a start-of-frame marker. The block does not buffer the frame. It compares each destination byte as it arrives and keeps one running equality flag for each entry.

One clock after the sixth destination byte is accepted, the block presents a result: a match flag and the index of the lowest-numbered entry that matched. The result stays in place until the next frame starts. Entry 0 is meant to hold the station's own address. The block only reports the result and never drops a frame, so the receive logic around it decides what to do with the flag.

Each 48-bit entry is split across a low word and a high word. The high word also carries a valid bit. Register writes land in a programming copy of the table. That copy is transferred to the compare copy at each start of frame, so a compare that is already running always sees one consistent table.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset every entry is invalid, and hitValid, hitFlag and hitIndex are all 0.
- R2: A write to word address 0x58 + 8*i loads address bytes 2, 3, 4 and 5 of entry i from data bits 31:24, 23:16, 15:8 and 7:0. Byte 0 is the first destination byte on the wire.
- R3: A write to word address 0x5C + 8*i loads address byte 0 of entry i from data bits 15:8, address byte 1 from bits 7:0, and the entry valid flag from bit 16. Writing zero to both words of an entry makes it invalid.
- R4: A destination byte is accepted only in a cycle with rxValid high. The accepted byte with rxSof high is byte 0, and the next five accepted bytes are bytes 1 to 5. A cycle with rxValid low is ignored, even when rxSof is high in that cycle.
- R5: hitValid rises in the clock edge that accepts byte 5, so it is visible one cycle after byte 5 is presented. It stays low while fewer bytes have been accepted. hitFlag is 1 when all six bytes equal a valid entry.
- R6: When several entries match, hitIndex gives the lowest-numbered one. When no entry matches, hitIndex is 0.
- R7: An invalid entry never matches, even when its stored address equals the destination.
- R8: A result holds until the next accepted rxSof byte. In the cycle after that byte, hitValid, hitFlag and hitIndex are all 0. A frame that restarts before reaching byte 5 produces no result.
- R9: A table write made while a frame is being compared does not affect that frame. It takes effect from the next frame.
- R10: A write is ignored when its address is below 0x58, is not a multiple of 4, or lies at or beyond 0x58 + 8*ENTRIES.
- R11: hitFlag is never 1 while hitValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte address |
| regWrData | input | 32 | Register write data |
| rxData | input | 8 | Received byte |
| rxValid | input | 1 | rxData holds a byte this cycle |
| rxSof | input | 1 | This byte is the first of a frame |
| hitValid | output | 1 | A match result is present |
| hitFlag | output | 1 | The destination matched a valid entry |
| hitIndex | output | IDX_W | Lowest matching entry index |

## Verification
The result registers are loaded in the same edge that accepts destination byte 5, and cleared in the edge that accepts an rxSof byte. Every result is therefore due one cycle after the byte that causes it. The bench drives each byte on a falling edge and samples the outputs on the falling edge that follows the byte-5 edge. It also samples once before that edge, to show that hitValid does not rise early. For table writes made during a frame, the bench first checks the frame in progress, then checks the following frames at the same sample points.

// File: rtl/pmf_pkg.sv
package pmf_pkg;

  localparam int MAC_BYTES = 6;
  localparam int CNT_W     = 3;

  // Strobes from control to datapath, one set per clock
  typedef struct packed {
    logic             first;  // byte 0 accepted
    logic             step;   // byte 1..5 accepted
    logic             last;   // byte 5 accepted
    logic [CNT_W-1:0] sel;    // position of the byte under step
  } pmfStrobes_t;

  // Byte k of a stored address, byte 0 in the top octet
  function automatic logic [7:0] pickByte(input logic [47:0] addr, input logic [CNT_W-1:0] k);
    case (k)
      3'd0:    pickByte = addr[47:40];
      3'd1:    pickByte = addr[39:32];
      3'd2:    pickByte = addr[31:24];
      3'd3:    pickByte = addr[23:16];
      3'd4:    pickByte = addr[15:8];
      3'd5:    pickByte = addr[7:0];
      default: pickByte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/pmf_table.sv
module pmf_table #(
  parameter int ENTRIES    = 4,
  parameter int ADDR_W     = 8,
  parameter int TABLE_BASE = 'h58,
  parameter int IDX_W      = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWrEn,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [31:0]              regWrData,
  output logic [ENTRIES-1:0][47:0] shadowAddr,
  output logic [ENTRIES-1:0]       shadowValid
);

  localparam int SPAN = ENTRIES * 8;

  logic [ADDR_W-1:0] offset;
  logic              inTable;
  logic [IDX_W-1:0]  entrySel;
  logic              isHigh;
  logic              unusedHiBits;

  assign offset       = regAddr - ADDR_W'(TABLE_BASE);
  assign inTable      = regWrEn && (regAddr >= ADDR_W'(TABLE_BASE)) &&
                        (int'(offset) < SPAN) && (offset[1:0] == 2'b00);
  assign entrySel     = offset[IDX_W+2:3];
  assign isHigh       = offset[2];
  assign unusedHiBits = ^regWrData[31:17];

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        shadowAddr[g]  <= '0;
        shadowValid[g] <= 1'b0;
      end else if (inTable && entrySel == IDX_W'(g)) begin
        if (isHigh) begin
          shadowAddr[g][47:32] <= regWrData[15:0];
          shadowValid[g]       <= regWrData[16];
        end else begin
          shadowAddr[g][31:0]  <= regWrData;
        end
      end
    end
  end

endmodule

// File: rtl/pmf_ctrl.sv
module pmf_ctrl
  import pmf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        rxSof,
  output pmfStrobes_t strb
);

  localparam logic [CNT_W-1:0] DONE = CNT_W'(MAC_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAC_BYTES - 1);

  // number of destination bytes taken so far; DONE means idle
  logic [CNT_W-1:0] byteCnt;

  always_comb begin
    strb.first = rxValid && rxSof;
    strb.step  = rxValid && !rxSof && (byteCnt != '0) && (byteCnt < DONE);
    strb.last  = strb.step && (byteCnt == LAST);
    strb.sel   = byteCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           byteCnt <= DONE;
    else if (strb.first) byteCnt <= CNT_W'(1);
    else if (strb.step)  byteCnt <= byteCnt + CNT_W'(1);
  end

endmodule

// File: rtl/pmf_match.sv
module pmf_match
  import pmf_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pmfStrobes_t              strb,
  input  logic [7:0]               rxData,
  input  logic [ENTRIES-1:0][47:0] shadowAddr,
  input  logic [ENTRIES-1:0]       shadowValid,
  output logic                     hitValid,
  output logic                     hitFlag,
  output logic [IDX_W-1:0]         hitIndex
);

  logic [ENTRIES-1:0][47:0] activeAddr;
  logic [ENTRIES-1:0]       eqFlags;
  logic [ENTRIES-1:0]       nextEq;
  logic [IDX_W-1:0]         firstIdx;

  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    always_comb begin
      if (strb.first)
        nextEq[g] = shadowValid[g] && (shadowAddr[g][47:40] == rxData);
      else if (strb.step)
        nextEq[g] = eqFlags[g] && (pickByte(activeAddr[g], strb.sel) == rxData);
      else
        nextEq[g] = eqFlags[g];
    end
  end

  always_comb begin
    firstIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (nextEq[i]) firstIdx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeAddr <= '0;
      eqFlags    <= '0;
      hitValid   <= 1'b0;
      hitFlag    <= 1'b0;
      hitIndex   <= '0;
    end else begin
      if (strb.first) activeAddr <= shadowAddr;
      if (strb.first || strb.step) eqFlags <= nextEq;
      if (strb.first) begin
        hitValid <= 1'b0;
        hitFlag  <= 1'b0;
        hitIndex <= '0;
      end else if (strb.last) begin
        hitValid <= 1'b1;
        hitFlag  <= |nextEq;
        hitIndex <= firstIdx;
      end
    end
  end

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import pmf_pkg::*;
#(
  parameter int  ENTRIES    = 4,
  parameter int  ADDR_W     = 8,
  parameter int  TABLE_BASE = 'h58,
  localparam int IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic [7:0]        rxData,
  input  logic              rxValid,
  input  logic              rxSof,
  output logic              hitValid,
  output logic              hitFlag,
  output logic [IDX_W-1:0]  hitIndex
);

  logic [ENTRIES-1:0][47:0] shadowAddr;
  logic [ENTRIES-1:0]       shadowValid;
  pmfStrobes_t              strb;

  pmf_table #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TABLE_BASE(TABLE_BASE), .IDX_W(IDX_W)
  ) uTable (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .shadowAddr(shadowAddr), .shadowValid(shadowValid)
  );

  pmf_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxSof(rxSof), .strb(strb)
  );

  pmf_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) uMatch (
    .clk(clk), .rstN(rstN), .strb(strb), .rxData(rxData),
    .shadowAddr(shadowAddr), .shadowValid(shadowValid),
    .hitValid(hitValid), .hitFlag(hitFlag), .hitIndex(hitIndex)
  );

endmodule

// File: rtl/dest_addr_filter_chk.sv
module dest_addr_filter_chk #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxValid,
  input logic             rxSof,
  input logic             hitValid,
  input logic             hitFlag,
  input logic [IDX_W-1:0] hitIndex
);

  // R11
  flag_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitFlag |-> hitValid);

  // R8
  sof_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxSof) |=> (!hitValid && !hitFlag && hitIndex == '0));

  // R8
  result_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitValid && !(rxValid && rxSof)) |=> (hitValid && $stable(hitFlag) && $stable(hitIndex)));

  // R6
  miss_index_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hitFlag |-> (hitIndex == '0));

  // R5
  rise_after_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hitValid) |-> $past(rxValid && !rxSof));

endmodule

bind dest_addr_filter dest_addr_filter_chk #(.IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxSof(rxSof),
  .hitValid(hitValid), .hitFlag(hitFlag), .hitIndex(hitIndex)
);

// File: tb/dest_addr_filter_test.sv
module dest_addr_filter_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [7:0]  rxData = '0;
  logic        rxValid = 1'b0;
  logic        rxSof = 1'b0;
  logic        hitValid, hitFlag;
  logic [1:0]  hitIndex;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  dest_addr_filter uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .rxData(rxData), .rxValid(rxValid), .rxSof(rxSof),
    .hitValid(hitValid), .hitFlag(hitFlag), .hitIndex(hitIndex)
  );

  // {destination, expected flag, expected index}
  localparam logic [50:0] VEC [6] = '{
    {48'h021122334455, 1'b1, 2'd0},  // R2 R3 own address
    {48'hAABBCCDDEEFF, 1'b1, 2'd1},  // R6 entries 1 and 3 both match
    {48'hAABBCCDDEEFE, 1'b0, 2'd0},  // R5 last byte differs
    {48'h031122334455, 1'b0, 2'd0},  // R5 first byte differs
    {48'h000000000000, 1'b0, 2'd0},  // R7 entry 2 zero and invalid
    {48'h021122334456, 1'b0, 2'd0}   // R2 byte 5 differs
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic checkResult(input string tag, input logic v, input logic f, input logic [1:0] idx);
    check({tag, " valid"}, {7'd0, hitValid}, {7'd0, v});
    check({tag, " flag"},  {7'd0, hitFlag},  {7'd0, f});
    check({tag, " index"}, {6'd0, hitIndex}, {6'd0, idx});
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic writeEntry(input int i, input logic [47:0] mac, input logic v);
    regWrite(8'(8'h58 + 8 * i), mac[31:0]);
    regWrite(8'(8'h5C + 8 * i), {15'd0, v, mac[47:32]});
  endtask

  task automatic sendByte(input logic [7:0] d, input logic s);
    @(negedge clk);
    rxData = d; rxValid = 1'b1; rxSof = s;
  endtask

  task automatic idle(input logic junkSof);
    @(negedge clk);
    rxData = 8'h5A; rxValid = 1'b0; rxSof = junkSof;
  endtask

  // sends six destination bytes, then one idle; outputs are sampled right after
  task automatic sendDest(input logic [47:0] mac);
    for (int b = 0; b < 6; b++) sendByte(mac[47 - 8 * b -: 8], b == 0);
    idle(1'b0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkResult("R1 reset", 1'b0, 1'b0, 2'd0);
    sendDest(48'h000000000000);
    checkResult("R1 empty table", 1'b1, 1'b0, 2'd0);

    writeEntry(0, 48'h021122334455, 1'b1);
    writeEntry(1, 48'hAABBCCDDEEFF, 1'b1);
    writeEntry(3, 48'hAABBCCDDEEFF, 1'b1);

    for (int v = 0; v < 6; v++) begin
      sendDest(VEC[v][50:3]);
      checkResult($sformatf("R5 vector %0d", v), 1'b1, VEC[v][2], VEC[v][1:0]);
    end

    // R4 R5: gaps, junk rxSof while invalid, no early result
    sendByte(8'hAA, 1'b1);
    idle(1'b1);
    for (int b = 1; b < 5; b++) sendByte(8'hAA + 8'(b * 8'h11), 1'b0);
    idle(1'b0);
    check("R5 not before byte 5", {7'd0, hitValid}, 8'd0);
    sendByte(8'hFF, 1'b0);
    idle(1'b0);
    checkResult("R4 gapped frame", 1'b1, 1'b1, 2'd1);

    // R8: payload keeps result, short frame gives none
    sendByte(8'h12, 1'b0); sendByte(8'h34, 1'b0); idle(1'b0);
    checkResult("R8 held", 1'b1, 1'b1, 2'd1);
    sendByte(8'h02, 1'b1); idle(1'b0);
    checkResult("R8 cleared on sof", 1'b0, 1'b0, 2'd0);
    sendByte(8'h11, 1'b0); sendByte(8'h22, 1'b0);
    sendDest(48'h021122334455);
    checkResult("R8 restarted frame", 1'b1, 1'b1, 2'd0);

    // R10: illegal writes ignored (0x78/0x7C would alias entry 0)
    regWrite(8'h50, 32'hFFFFFFFF);
    regWrite(8'h5A, 32'hFFFFFFFF);
    regWrite(8'h5D, 32'h0001FFFF);
    regWrite(8'h78, 32'hFFFFFFFF);
    regWrite(8'h7C, 32'h0001FFFF);
    sendDest(48'h021122334455);
    checkResult("R10 entry0 intact", 1'b1, 1'b1, 2'd0);
    sendDest(48'hFFFFFFFFFFFF);
    checkResult("R10 no alias", 1'b1, 1'b0, 2'd0);

    // R9: rewrite entry0 low word during a frame
    sendByte(8'h02, 1'b1);
    @(negedge clk);
    rxData = 8'h11; rxValid = 1'b1; rxSof = 1'b0;
    regWrEn = 1'b1; regAddr = 8'h58; regWrData = 32'h99887766;
    @(negedge clk);
    regWrEn = 1'b0;
    rxData = 8'h22;
    sendByte(8'h33, 1'b0); sendByte(8'h44, 1'b0); sendByte(8'h55, 1'b0);
    idle(1'b0);
    checkResult("R9 frame in progress", 1'b1, 1'b1, 2'd0);
    sendDest(48'h021122334455);
    checkResult("R9 old address gone", 1'b1, 1'b0, 2'd0);
    sendDest(48'h021199887766);
    checkResult("R9 new address", 1'b1, 1'b1, 2'd0);

    // R3 R7: clearing and zero-address valid entry
    writeEntry(0, 48'h0, 1'b0);
    sendDest(48'h021199887766);
    checkResult("R3 cleared entry", 1'b1, 1'b0, 2'd0);
    regWrite(8'h6C, 32'h00010000);
    sendDest(48'h000000000000);
    checkResult("R3 valid bit", 1'b1, 1'b1, 2'd2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule